// File: doc/BRIEF.md
# Interference mute arbitration controller

This block sits on a multiplex audio sample stream and gates it to zero when either of two impulse-interference detectors reports a hit. The first detector looks at the high-frequency content of the multiplex path. The second looks at the RF level signal. Each detector has its own enable. A hit from any enabled detector starts a mute window that lasts a programmable number of sample periods. Only cycles that carry the sample-valid strobe are counted, so gaps in the stream stretch the window in time but not in samples.

A separate override flag is raised while the signal shows excessive frequency deviation. Under that condition amplitude ripple could look like ignition noise. Raising the flag ends any mute in the same cycle and blocks new ones until the flag has dropped. A sticky cause field records which detector or detectors started the last accepted mute. A register write clears it.

The controller is a three-state machine:

- **ST_PASS**: samples pass unchanged.
- **ST_MUTE**: samples are zeroed and the counter is active.
- **ST_HOLD**: the override is in force.

The transitions are:

- **PASS→MUTE** on an accepted hit.
- **MUTE→MUTE (reload)** on a hit during a mute.
- **MUTE→PASS** when the last counted sample is taken.
- **PASS→HOLD** and **MUTE→HOLD** when the override is raised.
- **HOLD→PASS** when the override is found low.

Top module: `imute_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `mute_o`=0, `cause_o`=2'b00, `smp_vld_o`=0 and `smp_o`=0.
- R2: Outside a mute, each sample presented with `smp_vld_i`=1 appears unchanged on `smp_o`, with `smp_vld_o`=1, exactly one clock later.
- R3: A high-frequency detector pulse (`hf_pulse_i`=1 with `hf_en_i`=1, override low, `mute_len_i`=N>0) zeroes the next N valid samples after the pulse cycle. `mute_o` goes high the cycle after the pulse and falls the cycle after the N-th muted sample. A sample in the pulse cycle itself passes.
- R4: A level detector pulse (`lvl_pulse_i` with `lvl_en_i`=1) mutes in the same way, independently of the other detector.
- R5: A pulse from a detector whose enable is 0 has no effect on `mute_o`, `smp_o` or `cause_o`.
- R6: An accepted pulse during a mute reloads the count. The next N valid samples after that pulse are zeroed.
- R7: While `ovr_i`=1, samples pass unchanged, `mute_o` is 0 from the next cycle, and pulses are ignored. This includes the first cycle in which `ovr_i` reads 0 again. An active mute ends at once: the sample in the override's first cycle already passes.
- R8: With `mute_len_i`=0, pulses are ignored.
- R9: On every accepted pulse, `cause_o` is replaced: bit 0 is set if the high-frequency detector fired, and bit 1 is set if the level detector fired. The value persists after the mute ends.
- R10: `cause_clr_i`=1 sets `cause_o` to 0 in the next cycle. An accepted pulse in the same cycle takes precedence.
- R11: Only cycles with `smp_vld_i`=1 count toward the mute length. Idle cycles keep the mute active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Input sample strobe |
| smp_i | input | DW | Input sample |
| hf_pulse_i | input | 1 | High-frequency detector hit |
| lvl_pulse_i | input | 1 | RF-level detector hit |
| hf_en_i | input | 1 | Enable for high-frequency detector |
| lvl_en_i | input | 1 | Enable for level detector |
| ovr_i | input | 1 | Deviation override, suppresses muting |
| mute_len_i | input | LW | Mute length in samples |
| cause_clr_i | input | 1 | Clear sticky cause field |
| smp_o | output | DW | Gated sample |
| smp_vld_o | output | 1 | Output sample strobe |
| mute_o | output | 1 | Mute active |
| cause_o | output | 2 | Sticky cause: bit 0 = HF detector, bit 1 = level detector |

## Verification
Every result of this block is due one clock after the edge that samples its stimulus:

- the gated sample and its strobe;
- `mute_o` after a pulse, after the last counted sample, or after the override rises;
- `cause_o` after a pulse or a clear.

The bench drives each stimulus at a falling edge and reads the outputs at the following falling edge. That point lies half a period after the edge that must have updated them. Samples are sent with idle cycles between them, which makes the strobe-only counting visible at the output.

// File: rtl/imute_pkg.sv
package imute_pkg;
    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_MUTE = 2'd1,
        ST_HOLD = 2'd2
    } imute_st_e;

    localparam int unsigned SRC_N = 2;
    localparam int unsigned SRC_HF = 0;
    localparam int unsigned SRC_LVL = 1;
endpackage

// File: rtl/imute_req.sv
module imute_req
    import imute_pkg::*;
#(
    parameter int unsigned LW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] pulse_i,
    input  logic [SRC_N-1:0] en_i,
    input  logic             ovr_i,
    input  logic             hold_i,
    input  logic [LW-1:0]    len_i,
    input  logic             clr_i,
    output logic             accept_o,
    output logic [SRC_N-1:0] cause_o
);
    logic [SRC_N-1:0] hit;
    logic [SRC_N-1:0] cause_q;

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign hit[g] = pulse_i[g] & en_i[g];
    end

    always_comb begin
        accept_o = (|hit) && (len_i != '0) && !ovr_i && !hold_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (accept_o) begin
            cause_q <= hit;
        end else if (clr_i) begin
            cause_q <= '0;
        end
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/imute_fsm.sv
module imute_fsm
    import imute_pkg::*;
#(
    parameter int unsigned LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          ovr_i,
    input  logic          vld_i,
    input  logic [LW-1:0] len_i,
    output imute_st_e     st_o,
    output logic          mute_o,
    output logic          zero_o,
    output logic          hold_o
);
    localparam logic [LW-1:0] ONE = LW'(1);

    imute_st_e     st_q, st_d;
    logic [LW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_PASS;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_PASS: begin
                if (ovr_i) begin
                    st_d = ST_HOLD;
                end else if (accept_i) begin
                    st_d  = ST_MUTE;
                    cnt_d = len_i;
                end
            end
            ST_MUTE: begin
                if (ovr_i) begin
                    st_d  = ST_HOLD;
                    cnt_d = '0;
                end else if (accept_i) begin
                    cnt_d = len_i;
                end else if (vld_i) begin
                    if (cnt_q <= ONE) begin
                        st_d  = ST_PASS;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            ST_HOLD: begin
                if (!ovr_i) begin
                    st_d = ST_PASS;
                end
            end
            default: begin
                st_d  = ST_PASS;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        st_o   = st_q;
        mute_o = (st_q == ST_MUTE);
        zero_o = (st_q == ST_MUTE) && !ovr_i;
        hold_o = (st_q == ST_HOLD);
    end
endmodule

// File: rtl/imute_gate.sv
module imute_gate #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] smp_i,
    input  logic          zero_i,
    output logic          vld_o,
    output logic [DW-1:0] smp_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            smp_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                smp_o <= zero_i ? '0 : smp_i;
            end
        end
    end
endmodule

// File: rtl/imute_ctrl.sv
module imute_ctrl
    import imute_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld_i,
    input  logic [DW-1:0] smp_i,
    input  logic          hf_pulse_i,
    input  logic          lvl_pulse_i,
    input  logic          hf_en_i,
    input  logic          lvl_en_i,
    input  logic          ovr_i,
    input  logic [LW-1:0] mute_len_i,
    input  logic          cause_clr_i,
    output logic [DW-1:0] smp_o,
    output logic          smp_vld_o,
    output logic          mute_o,
    output logic [1:0]    cause_o
);
    logic [SRC_N-1:0] pulse_w, en_w, cause_w;
    logic             accept_w, hold_w, zero_w;
    imute_st_e        st_w;

    assign pulse_w[SRC_HF]  = hf_pulse_i;
    assign pulse_w[SRC_LVL] = lvl_pulse_i;
    assign en_w[SRC_HF]     = hf_en_i;
    assign en_w[SRC_LVL]    = lvl_en_i;

    imute_req #(.LW(LW)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_i  (pulse_w),
        .en_i     (en_w),
        .ovr_i    (ovr_i),
        .hold_i   (hold_w),
        .len_i    (mute_len_i),
        .clr_i    (cause_clr_i),
        .accept_o (accept_w),
        .cause_o  (cause_w)
    );

    imute_fsm #(.LW(LW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept_w),
        .ovr_i    (ovr_i),
        .vld_i    (smp_vld_i),
        .len_i    (mute_len_i),
        .st_o     (st_w),
        .mute_o   (mute_o),
        .zero_o   (zero_w),
        .hold_o   (hold_w)
    );

    imute_gate #(.DW(DW)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (smp_vld_i),
        .smp_i  (smp_i),
        .zero_i (zero_w),
        .vld_o  (smp_vld_o),
        .smp_o  (smp_o)
    );

    assign cause_o = cause_w;
endmodule

// File: rtl/imute_ctrl_chk.sv
module imute_ctrl_chk #(
    parameter int unsigned DW = 16,
    parameter int unsigned LW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld_i,
    input logic [DW-1:0] smp_i,
    input logic          hf_pulse_i,
    input logic          lvl_pulse_i,
    input logic          hf_en_i,
    input logic          lvl_en_i,
    input logic          ovr_i,
    input logic [LW-1:0] mute_len_i,
    input logic          cause_clr_i,
    input logic [DW-1:0] smp_o,
    input logic          smp_vld_o,
    input logic          mute_o,
    input logic [1:0]    cause_o,
    input logic          accept_w,
    input logic          hold_w
);
    AST_OVR_UNMUTES: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_i |=> !mute_o); // R7

    AST_OVR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_i && smp_vld_i) |=> (smp_vld_o && smp_o == $past(smp_i))); // R7

    AST_IDLE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_o && smp_vld_i) |=> (smp_vld_o && smp_o == $past(smp_i))); // R2

    AST_MUTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_o && !ovr_i && smp_vld_i) |=> (smp_o == '0)); // R3

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_o && !(hf_pulse_i && hf_en_i) && !(lvl_pulse_i && lvl_en_i)) |=> !mute_o); // R5

    AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_o && mute_len_i == '0) |=> !mute_o); // R8

    AST_HIT_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        ((hf_pulse_i && hf_en_i || lvl_pulse_i && lvl_en_i) && !ovr_i && !hold_w
         && mute_len_i != '0) |=> mute_o); // R3

    AST_CAUSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_clr_i && !accept_w) |=> (cause_o == 2'b00)); // R10

    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_clr_i && !accept_w) |=> $stable(cause_o)); // R9
endmodule

bind imute_ctrl imute_ctrl_chk #(.DW(DW), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_vld_i   (smp_vld_i),
    .smp_i       (smp_i),
    .hf_pulse_i  (hf_pulse_i),
    .lvl_pulse_i (lvl_pulse_i),
    .hf_en_i     (hf_en_i),
    .lvl_en_i    (lvl_en_i),
    .ovr_i       (ovr_i),
    .mute_len_i  (mute_len_i),
    .cause_clr_i (cause_clr_i),
    .smp_o       (smp_o),
    .smp_vld_o   (smp_vld_o),
    .mute_o      (mute_o),
    .cause_o     (cause_o),
    .accept_w    (accept_w),
    .hold_w      (hold_w)
);

// File: tb/imute_ctrl_bench.sv
module imute_ctrl_bench;
    localparam int unsigned DW = 16;
    localparam int unsigned LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld_i = 1'b0;
    logic [DW-1:0] smp_i = '0;
    logic          hf_pulse_i = 1'b0;
    logic          lvl_pulse_i = 1'b0;
    logic          hf_en_i = 1'b1;
    logic          lvl_en_i = 1'b1;
    logic          ovr_i = 1'b0;
    logic [LW-1:0] mute_len_i = 8'd3;
    logic          cause_clr_i = 1'b0;
    logic [DW-1:0] smp_o;
    logic          smp_vld_o;
    logic          mute_o;
    logic [1:0]    cause_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    imute_ctrl #(.DW(DW), .LW(LW)) u_imute_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld_i   (smp_vld_i),
        .smp_i       (smp_i),
        .hf_pulse_i  (hf_pulse_i),
        .lvl_pulse_i (lvl_pulse_i),
        .hf_en_i     (hf_en_i),
        .lvl_en_i    (lvl_en_i),
        .ovr_i       (ovr_i),
        .mute_len_i  (mute_len_i),
        .cause_clr_i (cause_clr_i),
        .smp_o       (smp_o),
        .smp_vld_o   (smp_vld_o),
        .mute_o      (mute_o),
        .cause_o     (cause_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // one valid sample; output checked one clock later
    task automatic send(input string req, input logic [DW-1:0] d, input bit muted);
        @(negedge clk);
        smp_vld_i = 1'b1;
        smp_i = d;
        @(negedge clk);
        smp_vld_i = 1'b0;
        check({req, " vld"}, int'(smp_vld_o), 1);
        check({req, " data"}, int'(smp_o), muted ? 0 : int'(d));
    endtask

    task automatic pulse(input bit hf, input bit lvl);
        @(negedge clk);
        hf_pulse_i = hf;
        lvl_pulse_i = lvl;
        @(negedge clk);
        hf_pulse_i = 1'b0;
        lvl_pulse_i = 1'b0;
    endtask

    task automatic clear_cause();
        @(negedge clk);
        cause_clr_i = 1'b1;
        @(negedge clk);
        cause_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 mute", int'(mute_o), 0);
        check("R1 cause", int'(cause_o), 0);
        check("R1 vld", int'(smp_vld_o), 0);
        check("R1 data", int'(smp_o), 0);
    endtask

    task automatic t_pass();
        send("R2 a", 16'h1234, 0);
        send("R2 b", 16'hFFFF, 0);
        send("R2 c", 16'h0001, 0);
    endtask

    task automatic t_hf();
        mute_len_i = 8'd3;
        pulse(1, 0);
        check("R3 mute rise", int'(mute_o), 1);
        send("R3 s1", 16'h1111, 1);
        send("R3 s2", 16'h2222, 1);
        check("R3 still muted", int'(mute_o), 1);
        send("R3 s3", 16'h3333, 1);
        check("R3 mute fall", int'(mute_o), 0);
        send("R3 s4", 16'h4444, 0);
        check("R9 hf cause", int'(cause_o), 1);
    endtask

    task automatic t_pulse_cycle_sample();
        // sample in the same cycle as the pulse passes
        @(negedge clk);
        hf_pulse_i = 1'b1;
        smp_vld_i = 1'b1;
        smp_i = 16'h5A5A;
        @(negedge clk);
        hf_pulse_i = 1'b0;
        smp_vld_i = 1'b0;
        check("R3 pulse-cycle sample", int'(smp_o), 16'h5A5A);
        check("R3 mute after pulse", int'(mute_o), 1);
        send("R3 m1", 16'h0101, 1);
        send("R3 m2", 16'h0202, 1);
        send("R3 m3", 16'h0303, 1);
        send("R3 after", 16'h0404, 0);
    endtask

    task automatic t_lvl();
        mute_len_i = 8'd2;
        hf_en_i = 1'b0;
        pulse(0, 1);
        check("R4 mute", int'(mute_o), 1);
        send("R4 s1", 16'hAAAA, 1);
        send("R4 s2", 16'hBBBB, 1);
        send("R4 s3", 16'hCCCC, 0);
        check("R9 lvl cause persists", int'(cause_o), 2);
        hf_en_i = 1'b1;
    endtask

    task automatic t_disabled();
        clear_cause();
        check("R10 clear", int'(cause_o), 0);
        hf_en_i = 1'b0;
        lvl_en_i = 1'b0;
        pulse(1, 1);
        check("R5 no mute", int'(mute_o), 0);
        send("R5 pass", 16'h7777, 0);
        check("R5 no cause", int'(cause_o), 0);
        hf_en_i = 1'b1;
        lvl_en_i = 1'b1;
    endtask

    task automatic t_restart();
        mute_len_i = 8'd3;
        pulse(1, 1);
        check("R9 both cause", int'(cause_o), 3);
        send("R6 a1", 16'h0A01, 1);
        send("R6 a2", 16'h0A02, 1);
        pulse(0, 1);
        check("R9 replaced cause", int'(cause_o), 2);
        send("R6 b1", 16'h0B01, 1);
        send("R6 b2", 16'h0B02, 1);
        send("R6 b3", 16'h0B03, 1);
        send("R6 b4", 16'h0B04, 0);
    endtask

    task automatic t_gaps();
        mute_len_i = 8'd2;
        pulse(1, 0);
        repeat (10) @(negedge clk);
        check("R11 idle keeps mute", int'(mute_o), 1);
        send("R11 s1", 16'h0C01, 1);
        repeat (5) @(negedge clk);
        check("R11 still muted", int'(mute_o), 1);
        send("R11 s2", 16'h0C02, 1);
        check("R11 end", int'(mute_o), 0);
    endtask

    task automatic t_override();
        mute_len_i = 8'd4;
        pulse(1, 0);
        send("R7 pre", 16'h0D01, 1);
        @(negedge clk);
        ovr_i = 1'b1;
        smp_vld_i = 1'b1;
        smp_i = 16'h0D02;
        @(negedge clk);
        smp_vld_i = 1'b0;
        check("R7 immediate pass", int'(smp_o), 16'h0D02);
        check("R7 mute ended", int'(mute_o), 0);
        pulse(1, 1);
        check("R7 blocked", int'(mute_o), 0);
        send("R7 pass held", 16'h0D03, 0);
        // release cycle: a pulse then is still ignored
        @(negedge clk);
        ovr_i = 1'b0;
        hf_pulse_i = 1'b1;
        @(negedge clk);
        hf_pulse_i = 1'b0;
        check("R7 release cycle", int'(mute_o), 0);
        send("R7 after release", 16'h0D04, 0);
        pulse(1, 0);
        check("R7 mutes again", int'(mute_o), 1);
        send("R7 r1", 16'h0E01, 1);
        send("R7 r2", 16'h0E02, 1);
        send("R7 r3", 16'h0E03, 1);
        send("R7 r4", 16'h0E04, 1);
        send("R7 r5", 16'h0E05, 0);
    endtask

    task automatic t_zero_len();
        mute_len_i = 8'd0;
        clear_cause();
        pulse(1, 1);
        check("R8 no mute", int'(mute_o), 0);
        check("R8 no cause", int'(cause_o), 0);
        send("R8 pass", 16'h0F0F, 0);
        mute_len_i = 8'd2;
    endtask

    task automatic t_clr_race();
        @(negedge clk);
        cause_clr_i = 1'b1;
        hf_pulse_i = 1'b1;
        @(negedge clk);
        cause_clr_i = 1'b0;
        hf_pulse_i = 1'b0;
        check("R10 pulse wins", int'(cause_o), 1);
        send("R10 m1", 16'h1001, 1);
        send("R10 m2", 16'h1002, 1);
        check("R9 persists", int'(cause_o), 1);
        clear_cause();
        check("R10 cleared", int'(cause_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pass();
        t_hf();
        t_pulse_cycle_sample();
        t_lvl();
        t_disabled();
        t_restart();
        t_gaps();
        t_override();
        t_zero_len();
        t_clr_race();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule